// File: doc/BRIEF.md
# Dual-Channel Serial Controller Register Interface

This block is the host-side register file of a two-channel serial controller. The host reaches each channel through two byte ports: a command port and a data port. Registers are addressed indirectly. The first write to a channel's command port loads a 4-bit pointer. The next command-port write stores its byte into the write register that the pointer selects. A command-port read returns the selected read register. After either the second write or the read, the pointer falls back to register 0.

A data-port write hands a byte to the transmitter, which is a plain valid/channel/byte strobe one cycle later. A data-port read pops a byte from that channel's small receive FIFO. The FIFO is fed from an external per-channel receive strobe. When local loopback is on, it is fed instead from the channel's own transmitted bytes.

Transmit, receive and external pending bits for both channels are gathered in one pending register. That register lives only in channel A and clears itself when read. A single interrupt output is gated by the master enable in channel A's register 9 and by the per-channel enables in register 1.

Top module: `dual_sio_regs`

## Requirements
- R1: On a channel whose pointer is unarmed, a command-port write loads the pointer from wdata[3:0] and the upper bits are ignored. The next command-port write on that channel stores its byte into the selected write register and returns the pointer to 0.
- R2: A command-port read returns the read register selected by the pointer and then returns the pointer to 0, so an unselected command read returns read register 0.
- R3: Read register 0 has bit 2 (transmit empty) always 1 and bit 0 (receive available) equal to "that channel's FIFO is not empty"; all other bits are 0. Read register 1 always reads 0x00.
- R4: Read registers 12 and 13 of a channel return the last bytes written to that channel's write registers 12 and 13; other read registers except 0 and 3 read 0x00.
- R5: A data-port write drives tx_valid=1 in the next cycle, with tx_chan equal to the channel and tx_byte equal to the written byte; tx_valid is 0 otherwise.
- R6: A data-port write sets the channel's transmit-pending bit when channel A write register 9 bit 3 (master enable) and that channel's write register 1 bit 1 (transmit enable) are both 1. Pending register bits are: bit 5 receive A, bit 4 transmit A, bit 3 external A, bit 2 receive B, bit 1 transmit B, bit 0 external B. While a transmit-pending bit and its enable are set, irq is 1.
- R7: When the master enable is 1 and channel A write register 1 bits 4:3 are nonzero (01 first-character, 10 all-characters), a non-empty FIFO sets its channel's receive-pending bit, and irq is 1.
- R8: The pending register is read register 3 of channel A. Reading it returns its content, clears all of its bits, and drops irq. Read register 3 of channel B reads 0x00 and clears nothing.
- R9: A data-port read returns the oldest FIFO byte and pops it, or returns 0x00 when the FIFO is empty. It also clears the whole pending register.
- R10: When write register 14 bit 4 of a channel is 1, each byte written to that channel's data port is pushed into its own FIFO, and the external receive strobe of that channel is ignored.
- R11: Each FIFO keeps FIFO_DEPTH bytes in arrival order. A push into a full FIFO drops the byte and sets that channel's overrun output, which stays 1 until reset.
- R12: While the master enable is 0, no pending bit is set and irq stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Host access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| sel_data | input | 1 | 0 = command port, 1 = data port |
| chan | input | 1 | Channel select, 0 = A, 1 = B |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte, valid in the cycle of a read access |
| rx_push | input | 2 | Per-channel external receive strobe |
| rx_byte | input | 16 | Per-channel receive byte, channel c at bits 8c+7:8c |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_chan | output | 1 | Channel of the transmitted byte |
| tx_byte | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |
| overrun | output | 2 | Sticky per-channel receive overrun flag |

## Verification
The hardest situation to reach is a pending register that is cleared while the FIFO still holds data, since the receive-pending bit then has to be set again in a later cycle. The bench reaches it with a directed sequence. It pushes a byte, waits for irq, reads the pending register through the pointer, and checks that irq has fallen before the byte is popped. Loopback with the external strobe ignored, and a fifth push into a full FIFO, are also driven directly. A seeded random mix of pushes and pops is then compared against a queue model in the bench.

// File: rtl/sio_pkg.sv
package sio_pkg;

    localparam int NCH      = 2;
    localparam int BYTE_W   = 8;
    localparam int PTR_W    = 4;

    // register indices the datapath decodes
    localparam logic [PTR_W-1:0] REG_STATUS  = 4'd0;
    localparam logic [PTR_W-1:0] REG_ERRS    = 4'd1;
    localparam logic [PTR_W-1:0] REG_PEND    = 4'd3;
    localparam logic [PTR_W-1:0] REG_INTCFG  = 4'd1;
    localparam logic [PTR_W-1:0] REG_MASTER  = 4'd9;
    localparam logic [PTR_W-1:0] REG_ECHO_LO = 4'd12;
    localparam logic [PTR_W-1:0] REG_ECHO_HI = 4'd13;
    localparam logic [PTR_W-1:0] REG_MISC    = 4'd14;

    // bit positions
    localparam int TXIE_BIT  = 1;
    localparam int RXM_LO    = 3;
    localparam int RXM_HI    = 4;
    localparam int MIE_BIT   = 3;
    localparam int LOOP_BIT  = 4;
    localparam int RXAV_BIT  = 0;
    localparam int TXE_BIT   = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_CMD_WR,
        ACC_CMD_RD,
        ACC_DAT_WR,
        ACC_DAT_RD
    } acc_t;

    // packed MSB first: bit5 .. bit0 of the pending register
    typedef struct packed {
        logic rx_a;
        logic tx_a;
        logic ext_a;
        logic rx_b;
        logic tx_b;
        logic ext_b;
    } pend_t;

    // the write registers that drive behaviour
    typedef struct packed {
        logic [BYTE_W-1:0] intcfg;
        logic [BYTE_W-1:0] master;
        logic [BYTE_W-1:0] echo_lo;
        logic [BYTE_W-1:0] echo_hi;
        logic [BYTE_W-1:0] misc;
    } chan_cfg_t;

    function automatic acc_t decode_acc(input logic cs, input logic we,
                                        input logic sel_data);
        if (!cs)
            return ACC_NONE;
        case ({sel_data, we})
            2'b00:   return ACC_CMD_RD;
            2'b01:   return ACC_CMD_WR;
            2'b10:   return ACC_DAT_RD;
            default: return ACC_DAT_WR;
        endcase
    endfunction

    function automatic logic [BYTE_W-1:0] status_byte(input logic rx_avail);
        logic [BYTE_W-1:0] s;
        s = '0;
        s[TXE_BIT]  = 1'b1;
        s[RXAV_BIT] = rx_avail;
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] pend_byte(input pend_t p);
        return {2'b00, p};
    endfunction

endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         overrun
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          pop_ok, push_ok;

    assign empty   = (cnt == '0);
    assign pop_ok  = pop && !empty;
    assign push_ok = push && ((cnt != FULL) || pop_ok);
    assign dout    = mem[rp];

    always_ff @(posedge clk) begin
        if (rst) begin
            wp      <= '0;
            rp      <= '0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            if (push_ok) begin
                mem[wp] <= din;
                wp      <= (wp == LAST) ? '0 : wp + 1'b1;
            end
            if (pop_ok)
                rp <= (rp == LAST) ? '0 : rp + 1'b1;
            if (push_ok && !pop_ok)
                cnt <= cnt + 1'b1;
            else if (pop_ok && !push_ok)
                cnt <= cnt - 1'b1;
            if (push && !push_ok)
                overrun <= 1'b1;
        end
    end

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= FULL);

    // R11
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overrun |=> overrun);

endmodule

// File: rtl/sio_chan_regs.sv
module sio_chan_regs
    import sio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic              cmd_rd,
    input  logic [BYTE_W-1:0] wdata,
    output logic [PTR_W-1:0]  ptr,
    output chan_cfg_t         cfg
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr   <= '0;
            armed <= 1'b0;
            cfg   <= '0;
        end else if (cmd_wr) begin
            if (!armed) begin
                ptr   <= wdata[PTR_W-1:0];
                armed <= 1'b1;
            end else begin
                case (ptr)
                    REG_INTCFG:  cfg.intcfg  <= wdata;
                    REG_MASTER:  cfg.master  <= wdata;
                    REG_ECHO_LO: cfg.echo_lo <= wdata;
                    REG_ECHO_HI: cfg.echo_hi <= wdata;
                    REG_MISC:    cfg.misc    <= wdata;
                    default: ;
                endcase
                ptr   <= '0;
                armed <= 1'b0;
            end
        end else if (cmd_rd) begin
            ptr   <= '0;
            armed <= 1'b0;
        end
    end

    // R1
    value_store_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && armed) |=> (!armed && ptr == '0));

    // R2
    read_rewind_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_rd |=> (!armed && ptr == '0));

endmodule

// File: rtl/sio_irq_ctrl.sv
module sio_irq_ctrl
    import sio_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           mie,
    input  logic [NCH-1:0] txie,
    input  logic           rx_en,
    input  logic [NCH-1:0] rx_ready,
    input  logic [NCH-1:0] tx_hit,
    input  logic           clr,
    output pend_t          pend,
    output logic           irq
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            pend <= '0;
        end else if (mie) begin
            if (tx_hit[0] && txie[0]) pend.tx_a <= 1'b1;
            if (tx_hit[1] && txie[1]) pend.tx_b <= 1'b1;
            if (rx_en && rx_ready[0]) pend.rx_a <= 1'b1;
            if (rx_en && rx_ready[1]) pend.rx_b <= 1'b1;
        end
    end

    assign irq = mie && ((txie[0] && pend.tx_a) || (txie[1] && pend.tx_b) ||
                         (rx_en && (pend.rx_a || pend.rx_b)));

    // R8
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (pend == '0));

    // R12
    master_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mie && !clr) |=> $stable(pend));

endmodule

// File: rtl/dual_sio_regs.sv
module dual_sio_regs
    import sio_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cs,
    input  logic                  we,
    input  logic                  sel_data,
    input  logic                  chan,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    input  logic [NCH-1:0]        rx_push,
    input  logic [NCH*BYTE_W-1:0] rx_byte,
    output logic                  tx_valid,
    output logic                  tx_chan,
    output logic [BYTE_W-1:0]     tx_byte,
    output logic                  irq,
    output logic [NCH-1:0]        overrun
);
    acc_t              acc;
    logic [PTR_W-1:0]  ptr      [NCH];
    chan_cfg_t         cfg      [NCH];
    logic [BYTE_W-1:0] head     [NCH];
    logic [NCH-1:0]    empty;
    logic [NCH-1:0]    txie;
    logic [NCH-1:0]    tx_hit;
    logic [NCH-1:0]    dat_rd_c;
    pend_t             pend;
    logic              clr;

    assign acc = decode_acc(cs, we, sel_data);

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic sel_me, loop_on;
        assign sel_me      = (chan == 1'(c));
        assign loop_on     = cfg[c].misc[LOOP_BIT];
        assign tx_hit[c]   = sel_me && (acc == ACC_DAT_WR);
        assign dat_rd_c[c] = sel_me && (acc == ACC_DAT_RD);
        assign txie[c]     = cfg[c].intcfg[TXIE_BIT];

        sio_chan_regs u_regs (
            .clk    (clk),
            .rst    (rst),
            .cmd_wr (sel_me && (acc == ACC_CMD_WR)),
            .cmd_rd (sel_me && (acc == ACC_CMD_RD)),
            .wdata  (wdata),
            .ptr    (ptr[c]),
            .cfg    (cfg[c])
        );

        sio_rx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .push    (loop_on ? tx_hit[c] : rx_push[c]),
            .din     (loop_on ? wdata : rx_byte[c*BYTE_W +: BYTE_W]),
            .pop     (dat_rd_c[c]),
            .dout    (head[c]),
            .empty   (empty[c]),
            .overrun (overrun[c])
        );
    end

    assign clr = (|dat_rd_c) ||
                 (acc == ACC_CMD_RD && chan == 1'b0 && ptr[0] == REG_PEND);

    sio_irq_ctrl u_irq (
        .clk      (clk),
        .rst      (rst),
        .mie      (cfg[0].master[MIE_BIT]),
        .txie     (txie),
        .rx_en    (|cfg[0].intcfg[RXM_HI:RXM_LO]),
        .rx_ready (~empty),
        .tx_hit   (tx_hit),
        .clr      (clr),
        .pend     (pend),
        .irq      (irq)
    );

    always_comb begin
        rdata = '0;
        if (acc == ACC_DAT_RD) begin
            rdata = empty[chan] ? '0 : head[chan];
        end else if (acc == ACC_CMD_RD) begin
            case (ptr[chan])
                REG_STATUS:  rdata = status_byte(!empty[chan]);
                REG_ERRS:    rdata = '0;
                REG_PEND:    rdata = (chan == 1'b0) ? pend_byte(pend) : '0;
                REG_ECHO_LO: rdata = cfg[chan].echo_lo;
                REG_ECHO_HI: rdata = cfg[chan].echo_hi;
                default:     rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_valid <= 1'b0;
            tx_chan  <= 1'b0;
            tx_byte  <= '0;
        end else begin
            tx_valid <= |tx_hit;
            if (|tx_hit) begin
                tx_chan <= chan;
                tx_byte <= wdata;
            end
        end
    end

    logic unused_cfg;
    assign unused_cfg = ^{cfg[0].intcfg, cfg[0].master, cfg[0].misc,
                          cfg[1].intcfg, cfg[1].master, cfg[1].misc};

    // R5
    tx_strobe_chk: assert property (@(posedge clk) disable iff (rst)
        (acc == ACC_DAT_WR) |=> (tx_valid && tx_byte == $past(wdata) &&
                                 tx_chan == $past(chan)));

    // R12
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> cfg[0].master[MIE_BIT]);

endmodule

// File: tb/sim_dual_sio_regs.sv
module sim_dual_sio_regs;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs = 1'b0, we = 1'b0, sel_data = 1'b0, chan = 1'b0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic [1:0]  rx_push = '0;
    logic [15:0] rx_byte = '0;
    logic        tx_valid, tx_chan, irq;
    logic [7:0]  tx_byte;
    logic [1:0]  overrun;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] mq [2][$];

    always #4 clk = ~clk;

    dual_sio_regs #(.FIFO_DEPTH(4)) u0 (
        .clk(clk), .rst(rst), .cs(cs), .we(we), .sel_data(sel_data),
        .chan(chan), .wdata(wdata), .rdata(rdata), .rx_push(rx_push),
        .rx_byte(rx_byte), .tx_valid(tx_valid), .tx_chan(tx_chan),
        .tx_byte(tx_byte), .irq(irq), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic access(input bit w, input bit d, input bit ch,
                          input logic [7:0] v, output logic [7:0] r);
        cs = 1'b1; we = w; sel_data = d; chan = ch; wdata = v;
        #1 r = rdata;
        @(posedge clk); @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic cmd_wr(input bit ch, input logic [7:0] v);
        logic [7:0] r;
        access(1'b1, 1'b0, ch, v, r);
    endtask

    task automatic set_reg(input bit ch, input logic [7:0] idx, input logic [7:0] v);
        cmd_wr(ch, idx);
        cmd_wr(ch, v);
    endtask

    task automatic cmd_rd(input bit ch, output logic [7:0] r);
        access(1'b0, 1'b0, ch, 8'h00, r);
    endtask

    task automatic get_reg(input bit ch, input logic [7:0] idx, output logic [7:0] r);
        cmd_wr(ch, idx);
        cmd_rd(ch, r);
    endtask

    task automatic dat_wr(input bit ch, input logic [7:0] v);
        logic [7:0] r;
        access(1'b1, 1'b1, ch, v, r);
    endtask

    task automatic dat_rd(input bit ch, output logic [7:0] r);
        access(1'b0, 1'b1, ch, 8'h00, r);
    endtask

    task automatic rx_in(input bit ch, input logic [7:0] v);
        rx_push[ch] = 1'b1;
        rx_byte[ch*8 +: 8] = v;
        @(posedge clk); @(negedge clk);
        rx_push = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_status(input int fill);
        return (fill != 0) ? 8'h05 : 8'h04;
    endfunction

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] r;
        idle(3);
        rst = 1'b0;
        idle(1);

        chk("R5 reset tx_valid", tx_valid, 0);
        chk("R6 reset irq", irq, 0);
        chk("R11 reset overrun", overrun, 0);
        cmd_rd(1'b0, r);
        chk("R3 status after reset", r, 8'h04);

        // R1 R4: pointer, store, echo; upper pointer bits ignored
        set_reg(1'b0, 8'h0C, 8'h5A);
        get_reg(1'b0, 8'h2C, r);
        chk("R4 echo lo A", r, 8'h5A);
        cmd_rd(1'b0, r);
        chk("R2 pointer back to 0", r, 8'h04);
        set_reg(1'b1, 8'hFD, 8'hC3);
        get_reg(1'b1, 8'h0D, r);
        chk("R1 store via masked pointer B", r, 8'hC3);
        get_reg(1'b0, 8'h0D, r);
        chk("R4 channel A reg13 untouched", r, 8'h00);
        get_reg(1'b0, 8'h01, r);
        chk("R3 error register", r, 8'h00);
        get_reg(1'b0, 8'h07, r);
        chk("R4 other register reads 0", r, 8'h00);

        // R5 transmit strobe
        dat_wr(1'b1, 8'h77);
        chk("R5 tx_valid", tx_valid, 1);
        chk("R5 tx_chan", tx_chan, 1);
        chk("R5 tx_byte", tx_byte, 8'h77);
        idle(1);
        chk("R5 tx_valid drops", tx_valid, 0);

        // R12: tx enable without master enable
        set_reg(1'b0, 8'h01, 8'h02);
        dat_wr(1'b0, 8'h10);
        idle(1);
        chk("R12 irq stays low", irq, 0);
        get_reg(1'b0, 8'h03, r);
        chk("R12 no pending", r, 8'h00);

        // R6 R8: transmit pending
        set_reg(1'b0, 8'h09, 8'h08);
        dat_wr(1'b0, 8'h11);
        chk("R6 irq on tx A", irq, 1);
        get_reg(1'b1, 8'h03, r);
        chk("R8 channel B reg3 reads 0", r, 8'h00);
        chk("R8 B read keeps irq", irq, 1);
        get_reg(1'b0, 8'h03, r);
        chk("R6 pending tx A", r, 8'h10);
        chk("R8 irq released", irq, 0);
        set_reg(1'b1, 8'h01, 8'h02);
        dat_wr(1'b1, 8'h12);
        chk("R6 irq on tx B", irq, 1);
        get_reg(1'b0, 8'h03, r);
        chk("R6 pending tx B", r, 8'h02);

        // R7: receive, all-characters mode
        set_reg(1'b0, 8'h01, 8'h10);
        rx_in(1'b1, 8'h33);
        idle(2);
        chk("R7 irq on rx B", irq, 1);
        get_reg(1'b0, 8'h03, r);
        chk("R7 pending rx B", r, 8'h04);
        chk("R8 clear with data still queued", irq, 0);
        cmd_rd(1'b1, r);
        chk("R3 status with data", r, exp_status(1));
        dat_rd(1'b1, r);
        chk("R9 pop byte", r, 8'h33);
        idle(2);
        chk("R9 irq low after pop", irq, 0);
        cmd_rd(1'b1, r);
        chk("R3 status empty", r, exp_status(0));

        // R7: first-character mode
        set_reg(1'b0, 8'h01, 8'h08);
        rx_in(1'b0, 8'h44);
        idle(2);
        get_reg(1'b0, 8'h03, r);
        chk("R7 pending rx A", r, 8'h20);
        dat_rd(1'b0, r);
        chk("R9 pop A", r, 8'h44);
        dat_rd(1'b0, r);
        chk("R9 empty read", r, 8'h00);

        // R10 loopback
        set_reg(1'b1, 8'h0E, 8'h10);
        dat_wr(1'b1, 8'hA5);
        chk("R10 tx still sent", tx_byte, 8'hA5);
        rx_in(1'b1, 8'h99);
        dat_rd(1'b1, r);
        chk("R10 looped byte", r, 8'hA5);
        dat_rd(1'b1, r);
        chk("R10 external byte ignored", r, 8'h00);
        set_reg(1'b1, 8'h0E, 8'h00);
        set_reg(1'b0, 8'h09, 8'h00);
        idle(1);
        chk("R12 irq off with master off", irq, 0);

        // R11 overflow
        for (int i = 0; i < 4; i++) rx_in(1'b0, 8'(8'hB0 + i));
        chk("R11 no overrun at full", overrun, 2'b00);
        rx_in(1'b0, 8'hEE);
        chk("R11 overrun set", overrun, 2'b01);
        for (int i = 0; i < 4; i++) begin
            dat_rd(1'b0, r);
            chk("R11 order kept", r, 8'hB0 + i);
        end
        dat_rd(1'b0, r);
        chk("R11 dropped byte absent", r, 8'h00);
        chk("R11 overrun sticky", overrun, 2'b01);

        // random push/pop mix against queue model (R9 R11)
        void'($urandom(32'd1234));
        for (int i = 0; i < 400; i++) begin
            bit ch;
            logic [7:0] v;
            ch = 1'($urandom);
            v = 8'($urandom);
            if ($urandom % 2 == 0) begin
                rx_in(ch, v);
                if (mq[ch].size() < 4) mq[ch].push_back(v);
            end else begin
                dat_rd(ch, r);
                if (mq[ch].size() != 0)
                    chk("R9 random pop", r, mq[ch].pop_front());
                else
                    chk("R9 random empty pop", r, 8'h00);
            end
        end
        cmd_rd(1'b1, r);
        chk("R3 random status B", r, exp_status(mq[1].size()));

        // reset clears overrun and FIFOs (R11)
        rst = 1'b1;
        idle(2);
        rst = 1'b0;
        idle(1);
        chk("R11 overrun cleared by reset", overrun, 2'b00);
        cmd_rd(1'b0, r);
        chk("R3 status after second reset", r, 8'h04);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule